// File: doc/BRIEF.md
# QC-LDPC Code Definition Checker

This block decides whether a quasi-cyclic LDPC code description can be held by the memories of a layered decoder or encoder. It does this before the code is loaded. A start pulse captures the per-code parameters: sub-matrix size, codeword length, parity length, declared layer count and an encode/decode flag. The same pulse clears all accumulated state. A stream of check node degrees follows, one word per layer. A last-layer marker closes the stream.

While the degrees arrive, the block derives the cycles-per-circulant factor MV = ceil(P/128). It checks every degree against its range and against the per-layer memory limit, and it keeps a saturating sum of the degrees and a count of the words. When the last word is accepted, the block shows a violation mask with one bit per rule and a pass flag. They are held until the next start pulse.

Top module: `qc_ldpc_code_checker`

## Requirements
- R1: After reset, and at any time while done_o is low, done_o, pass_o and viol_o are all zero.
- R2: start_i captures the parameters and clears the accumulators and done_o. A degree word presented in the same cycle as start_i is discarded. Degree words presented while no code is open (before the first start, or after done_o has risen) have no effect on the outputs.
- R3: done_o rises in the cycle after the clock edge that accepts a word with dc_last_i high. done_o, viol_o and pass_o then hold until the next start_i.
- R4: When done_o is high, pass_o is high exactly when viol_o is all zero.
- R5: MV = ceil(P/128). Bit 0 of viol_o is set when P < 2 or P > 512.
- R6: Codeword rules, each judged against the N input (16 bits). Bit 1 is set when N < 4 or N > 32768. Bit 2 is set when N is not a multiple of P, or when P = 0. Bit 3 is set when N > 256·P. Bit 7 is set when the parity length is not less than N, which means K = N − parity would not be positive.
- R7: Parity rules. Bit 4 is set when the parity length is below 2 or above 32766. Bit 5 is set when the parity length is not a multiple of P, or when P = 0. Bit 6 is set when the parity length exceeds 256·P.
- R8: Layer rules. Bit 8 is set when the declared layer count is outside 1..256. Bit 9 is set when layers·MV > 256.
- R9: Degree rules, sticky over the stream. Bit 10 is set when any accepted degree is outside 2..128. Bit 11 is set when any accepted degree satisfies degree·MV > 256.
- R10: Bit 12 is the degree-sum rule, and its test depends on the mode. In decode mode (encode_i = 0) it is set when sum·MV > 1024. In encode mode (encode_i = 1) it is set when sum > 2044.
- R11: Bit 13 is set only in encode mode, when N·MV > 256·P, which is equivalent to (N/P)·MV > 256 for a legal N. In decode mode it is never set.
- R12: Bit 14 is set when the number of accepted degree words differs from the declared layer count.
- R13: The 16-bit degree sum saturates at its maximum instead of wrapping. For example, 512 words of degree 128 in decode mode with P = 128 must still set bit 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Capture parameters, clear state |
| p_size_i | input | 10 | Sub-matrix size P |
| n_len_i | input | 16 | Codeword length N |
| nk_len_i | input | 16 | Parity length N−K |
| layers_i | input | 9 | Declared layer count |
| encode_i | input | 1 | 1 = encode limits, 0 = decode limits |
| dc_valid_i | input | 1 | Degree word valid |
| dc_i | input | 8 | Check node degree of one layer |
| dc_last_i | input | 1 | Marks the last layer's degree |
| done_o | output | 1 | Result valid |
| pass_o | output | 1 | Code legal |
| viol_o | output | 15 | Violated-rule mask, bit positions as in R5–R12 |

## Verification
Two things can fall in the same cycle: a new start pulse and a degree word, with the word possibly flagged as last. The bench provokes this by raising start_i together with dc_valid_i, an illegal degree of zero and dc_last_i. It then judges the outcome in two ways. done_o must stay low in the following cycle. The final mask must show neither a degree-range violation nor an extra word in the count. Sweeps over P, N, the mode and the degree patterns are compared against a mask computed arithmetically in the bench.

// File: rtl/qc_ldpc_pkg.sv
package qc_ldpc_pkg;
  localparam int P_W     = 10;
  localparam int LEN_W   = 16;
  localparam int LAY_W   = 9;
  localparam int DC_W    = 8;
  localparam int SUM_W   = 16;
  localparam int CNT_W   = 10;
  localparam int MV_W    = 4;
  localparam int LANES   = 128;

  localparam int P_MIN       = 2;
  localparam int P_MAX       = 512;
  localparam int N_MIN       = 4;
  localparam int N_MAX       = 32768;
  localparam int NK_MIN      = 2;
  localparam int NK_MAX      = 32766;
  localparam int LAY_MAX     = 256;
  localparam int DC_MIN      = 2;
  localparam int DC_MAX      = 128;
  localparam int ROW_MEM     = 256;
  localparam int BASE_COLS   = 256;
  localparam int DEC_SUM_MAX = 1024;
  localparam int ENC_SUM_MAX = 2044;

  localparam int NUM_RULES = 15;

  typedef enum int {
    RB_P_RANGE   = 0,
    RB_N_RANGE   = 1,
    RB_N_MULT    = 2,
    RB_N_CAP     = 3,
    RB_NK_RANGE  = 4,
    RB_NK_MULT   = 5,
    RB_NK_CAP    = 6,
    RB_K_POS     = 7,
    RB_LAY_RANGE = 8,
    RB_LAY_MEM   = 9,
    RB_DC_RANGE  = 10,
    RB_DC_MEM    = 11,
    RB_SUM_MEM   = 12,
    RB_ENC_COL   = 13,
    RB_LAY_MISM  = 14
  } rule_bit_e;
endpackage

// File: rtl/qc_ldpc_mv_calc.sv
module qc_ldpc_mv_calc #(
  parameter int P_W   = qc_ldpc_pkg::P_W,
  parameter int MV_W  = qc_ldpc_pkg::MV_W,
  parameter int LANES = qc_ldpc_pkg::LANES
) (
  input  logic [P_W-1:0]  p_i,
  output logic [MV_W-1:0] mv_o
);
  localparam int SH = $clog2(LANES);
  localparam int XW = P_W + 1;

  logic [XW-1:0] rnd;
  assign rnd  = XW'(p_i) + XW'(LANES - 1);
  assign mv_o = MV_W'(rnd >> SH);

  // R5: MV is the smallest lane-group count that covers P
  always_comb begin
    if (p_i >= P_W'(qc_ldpc_pkg::P_MIN) && p_i <= P_W'(qc_ldpc_pkg::P_MAX)) begin
      assert_mv_ceil_R5: assert ((int'(mv_o) * LANES >= int'(p_i)) &&
                                 ((int'(mv_o) - 1) * LANES < int'(p_i)));
    end
  end
endmodule

// File: rtl/qc_ldpc_param_rules.sv
module qc_ldpc_param_rules
  import qc_ldpc_pkg::*;
#(
  parameter int P_W   = qc_ldpc_pkg::P_W,
  parameter int LEN_W = qc_ldpc_pkg::LEN_W,
  parameter int LAY_W = qc_ldpc_pkg::LAY_W,
  parameter int MV_W  = qc_ldpc_pkg::MV_W,
  parameter int NR    = qc_ldpc_pkg::NUM_RULES
) (
  input  logic [P_W-1:0]   p_i,
  input  logic [LEN_W-1:0] n_i,
  input  logic [LEN_W-1:0] nk_i,
  input  logic [LAY_W-1:0] lay_i,
  input  logic             enc_i,
  input  logic [MV_W-1:0]  mv_i,
  output logic [NR-1:0]    viol_o
);
  localparam int CW = LEN_W + P_W + MV_W;

  logic [CW-1:0] p_x, n_x, nk_x, lay_x, mv_x, pd_x, cap_x;
  logic          p_zero;

  assign p_x    = CW'(p_i);
  assign n_x    = CW'(n_i);
  assign nk_x   = CW'(nk_i);
  assign lay_x  = CW'(lay_i);
  assign mv_x   = CW'(mv_i);
  assign p_zero = (p_i == '0);
  assign pd_x   = p_zero ? CW'(1) : p_x;
  assign cap_x  = p_x * CW'(BASE_COLS);

  always_comb begin
    viol_o               = '0;
    viol_o[RB_P_RANGE]   = (p_x < CW'(P_MIN)) || (p_x > CW'(P_MAX));
    viol_o[RB_N_RANGE]   = (n_x < CW'(N_MIN)) || (n_x > CW'(N_MAX));
    viol_o[RB_N_MULT]    = p_zero || ((n_x % pd_x) != '0);
    viol_o[RB_N_CAP]     = n_x > cap_x;
    viol_o[RB_NK_RANGE]  = (nk_x < CW'(NK_MIN)) || (nk_x > CW'(NK_MAX));
    viol_o[RB_NK_MULT]   = p_zero || ((nk_x % pd_x) != '0);
    viol_o[RB_NK_CAP]    = nk_x > cap_x;
    viol_o[RB_K_POS]     = nk_x >= n_x;
    viol_o[RB_LAY_RANGE] = (lay_x == '0) || (lay_x > CW'(LAY_MAX));
    viol_o[RB_LAY_MEM]   = (lay_x * mv_x) > CW'(ROW_MEM);
    viol_o[RB_ENC_COL]   = enc_i && ((n_x * mv_x) > cap_x);
  end
endmodule

// File: rtl/qc_ldpc_layer_acc.sv
module qc_ldpc_layer_acc #(
  parameter int DC_W  = qc_ldpc_pkg::DC_W,
  parameter int MV_W  = qc_ldpc_pkg::MV_W,
  parameter int SUM_W = qc_ldpc_pkg::SUM_W,
  parameter int CNT_W = qc_ldpc_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             acc_i,
  input  logic [DC_W-1:0]  dc_i,
  input  logic [MV_W-1:0]  mv_i,
  output logic [SUM_W-1:0] sum_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dc_range_o,
  output logic             dc_mem_o
);
  localparam int AW = DC_W + MV_W;

  logic [SUM_W-1:0] sum_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rng_q, mem_q;
  logic [SUM_W:0]   sum_nx;
  logic [AW-1:0]    dc_mv;
  logic             bad_rng, bad_mem;

  assign sum_nx  = {1'b0, sum_q} + (SUM_W+1)'(dc_i);
  assign dc_mv   = AW'(dc_i) * AW'(mv_i);
  assign bad_rng = (dc_i < DC_W'(qc_ldpc_pkg::DC_MIN)) || (dc_i > DC_W'(qc_ldpc_pkg::DC_MAX));
  assign bad_mem = dc_mv > AW'(qc_ldpc_pkg::ROW_MEM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      cnt_q <= '0;
      rng_q <= 1'b0;
      mem_q <= 1'b0;
    end else if (clr_i) begin
      sum_q <= '0;
      cnt_q <= '0;
      rng_q <= 1'b0;
      mem_q <= 1'b0;
    end else if (acc_i) begin
      sum_q <= sum_nx[SUM_W] ? '1 : sum_nx[SUM_W-1:0];
      if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      rng_q <= rng_q | bad_rng;
      mem_q <= mem_q | bad_mem;
    end
  end

  assign sum_o      = sum_q;
  assign cnt_o      = cnt_q;
  assign dc_range_o = rng_q;
  assign dc_mem_o   = mem_q;

  // R13: the sum never wraps downward while accumulating
  assert_sum_no_wrap_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !clr_i) |=> (sum_q >= $past(sum_q)));

  // R2: clear empties both accumulators
  assert_clear_empties_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (sum_q == '0 && cnt_q == '0 && !rng_q && !mem_q));
endmodule

// File: rtl/qc_ldpc_code_checker.sv
module qc_ldpc_code_checker
  import qc_ldpc_pkg::*;
#(
  parameter int P_W   = qc_ldpc_pkg::P_W,
  parameter int LEN_W = qc_ldpc_pkg::LEN_W,
  parameter int LAY_W = qc_ldpc_pkg::LAY_W,
  parameter int DC_W  = qc_ldpc_pkg::DC_W,
  parameter int SUM_W = qc_ldpc_pkg::SUM_W,
  parameter int CNT_W = qc_ldpc_pkg::CNT_W,
  parameter int MV_W  = qc_ldpc_pkg::MV_W,
  parameter int NR    = qc_ldpc_pkg::NUM_RULES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [P_W-1:0]   p_size_i,
  input  logic [LEN_W-1:0] n_len_i,
  input  logic [LEN_W-1:0] nk_len_i,
  input  logic [LAY_W-1:0] layers_i,
  input  logic             encode_i,
  input  logic             dc_valid_i,
  input  logic [DC_W-1:0]  dc_i,
  input  logic             dc_last_i,
  output logic             done_o,
  output logic             pass_o,
  output logic [NR-1:0]    viol_o
);
  localparam int SW = SUM_W + MV_W;
  localparam int KW = (CNT_W > LAY_W) ? CNT_W : LAY_W;

  logic [P_W-1:0]   p_q;
  logic [LEN_W-1:0] n_q, nk_q;
  logic [LAY_W-1:0] lay_q;
  logic             enc_q, busy_q, done_q;

  logic [MV_W-1:0]  mv;
  logic [NR-1:0]    static_viol, mask;
  logic [SUM_W-1:0] sum;
  logic [CNT_W-1:0] cnt;
  logic             dc_rng, dc_mem, accept, sum_bad;
  logic [SW-1:0]    sum_mv;

  // start wins over a coincident degree word
  assign accept = dc_valid_i && busy_q && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q    <= '0;
      n_q    <= '0;
      nk_q   <= '0;
      lay_q  <= '0;
      enc_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      p_q    <= p_size_i;
      n_q    <= n_len_i;
      nk_q   <= nk_len_i;
      lay_q  <= layers_i;
      enc_q  <= encode_i;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (accept && dc_last_i) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
    end
  end

  qc_ldpc_mv_calc #(.P_W(P_W), .MV_W(MV_W), .LANES(LANES)) mv_i (
    .p_i (p_q),
    .mv_o(mv)
  );

  qc_ldpc_param_rules #(
    .P_W(P_W), .LEN_W(LEN_W), .LAY_W(LAY_W), .MV_W(MV_W), .NR(NR)
  ) rules_i (
    .p_i   (p_q),
    .n_i   (n_q),
    .nk_i  (nk_q),
    .lay_i (lay_q),
    .enc_i (enc_q),
    .mv_i  (mv),
    .viol_o(static_viol)
  );

  qc_ldpc_layer_acc #(
    .DC_W(DC_W), .MV_W(MV_W), .SUM_W(SUM_W), .CNT_W(CNT_W)
  ) acc_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start_i),
    .acc_i     (accept),
    .dc_i      (dc_i),
    .mv_i      (mv),
    .sum_o     (sum),
    .cnt_o     (cnt),
    .dc_range_o(dc_rng),
    .dc_mem_o  (dc_mem)
  );

  assign sum_mv  = SW'(sum) * SW'(mv);
  assign sum_bad = enc_q ? (SW'(sum) > SW'(ENC_SUM_MAX)) : (sum_mv > SW'(DEC_SUM_MAX));

  always_comb begin
    mask               = static_viol;
    mask[RB_DC_RANGE]  = dc_rng;
    mask[RB_DC_MEM]    = dc_mem;
    mask[RB_SUM_MEM]   = sum_bad;
    mask[RB_LAY_MISM]  = KW'(cnt) != KW'(lay_q);
  end

  assign done_o = done_q;
  assign viol_o = done_q ? mask : '0;
  assign pass_o = done_q && (mask == '0);

  // R1: nothing reported while no result is valid
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (viol_o == '0 && !pass_o));

  // R2: start drops the result in the next cycle
  assert_start_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);

  // R3: last accepted word yields a result one cycle later
  assert_done_after_last_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dc_valid_i && dc_last_i && busy_q && !start_i) |=> done_o);

  // R3: result held until the next start
  assert_result_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(viol_o) && $stable(pass_o)));

  // R4: pass and any violation are exclusive
  assert_pass_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> (done_o && $countones(viol_o) == 0));
endmodule

// File: tb/qc_ldpc_code_checker_tb.sv
module qc_ldpc_code_checker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [9:0]  p_size = '0;
  logic [15:0] n_len = '0, nk_len = '0;
  logic [8:0]  layers = '0;
  logic        enc = 1'b0;
  logic        dc_valid = 1'b0;
  logic [7:0]  dc = '0;
  logic        dc_last = 1'b0;
  logic        done, pass;
  logic [14:0] viol;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  int cur_p, cur_n, cur_nk, cur_lay, cur_enc, cur_cnt;
  int dc_arr [0:599];

  always #4 clk = ~clk;

  qc_ldpc_code_checker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .p_size_i(p_size),
    .n_len_i(n_len), .nk_len_i(nk_len), .layers_i(layers), .encode_i(enc),
    .dc_valid_i(dc_valid), .dc_i(dc), .dc_last_i(dc_last),
    .done_o(done), .pass_o(pass), .viol_o(viol)
  );

  function automatic bit [14:0] ref_mask();
    bit [14:0] m = '0;
    int mv = (cur_p + 127) / 128;
    int sum = 0;
    bit rng = 0, mem = 0;
    for (int i = 0; i < cur_cnt; i++) begin
      sum += dc_arr[i];
      if (dc_arr[i] < 2 || dc_arr[i] > 128) rng = 1;
      if (dc_arr[i] * mv > 256) mem = 1;
    end
    if (sum > 65535) sum = 65535;
    m[0]  = (cur_p < 2) || (cur_p > 512);
    m[1]  = (cur_n < 4) || (cur_n > 32768);
    m[2]  = (cur_p == 0) ? 1'b1 : ((cur_n % cur_p) != 0);
    m[3]  = cur_n > 256 * cur_p;
    m[4]  = (cur_nk < 2) || (cur_nk > 32766);
    m[5]  = (cur_p == 0) ? 1'b1 : ((cur_nk % cur_p) != 0);
    m[6]  = cur_nk > 256 * cur_p;
    m[7]  = !(cur_n - cur_nk > 0);
    m[8]  = (cur_lay < 1) || (cur_lay > 256);
    m[9]  = cur_lay * mv > 256;
    m[10] = rng;
    m[11] = mem;
    m[12] = cur_enc ? (sum > 2044) : (sum * mv > 1024);
    m[13] = cur_enc && (cur_n * mv > 256 * cur_p);
    m[14] = cur_cnt != cur_lay;
    return m;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h (p=%0d n=%0d nk=%0d lay=%0d enc=%0d cnt=%0d)",
               tag, act, exp, cur_p, cur_n, cur_nk, cur_lay, cur_enc, cur_cnt);
    end
  endtask

  task automatic open_code(input int p, input int n, input int nk, input int lay, input int e);
    cur_p = p; cur_n = n; cur_nk = nk; cur_lay = lay; cur_enc = e;
    @(negedge clk);
    p_size = 10'(p); n_len = 16'(n); nk_len = 16'(nk); layers = 9'(lay); enc = e[0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic stream(input int cnt);
    cur_cnt = cnt;
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      dc_valid = 1'b1; dc = 8'(dc_arr[i]); dc_last = (i == cnt - 1);
    end
    @(negedge clk);
    dc_valid = 1'b0; dc_last = 1'b0;
  endtask

  task automatic judge(input string tag);
    bit [14:0] e = ref_mask();
    chk({tag, " done R3"}, int'(done), 1);
    chk({tag, " mask"}, int'(viol), int'(e));
    chk({tag, " pass R4"}, int'(pass), int'(e == '0));
  endtask

  task automatic run(input string tag, input int p, input int n, input int nk,
                     input int lay, input int e, input int cnt);
    open_code(p, n, nk, lay, e);
    stream(cnt);
    judge(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset pass", int'(pass), 0);
    chk("R1 reset viol", int'(viol), 0);
    rst_n = 1'b1;

    // R2: words before any start are ignored
    @(negedge clk);
    dc_valid = 1'b1; dc = 8'd0; dc_last = 1'b1;
    repeat (3) @(negedge clk);
    dc_valid = 1'b0; dc_last = 1'b0;
    @(negedge clk);
    chk("R2 idle words done", int'(done), 0);
    chk("R1 idle viol", int'(viol), 0);

    // R5 R8 R9 R10 R11: sweep P over all 10-bit values, one layer
    for (int p = 0; p < 1024; p++) begin
      dc_arr[0] = 100;
      run("R5 P sweep", p, p * 8, p * 2, 1, p % 2, 1);
    end

    // R6 R7: codeword and parity length sweeps
    for (int n = 0; n < 65536; n += 1531) begin
      dc_arr[0] = 64;
      run("R6 N sweep", 64, n, 128, 1, 1, 1);
      run("R7 NK sweep", 64, 4096, n, 1, 0, 1);
    end
    dc_arr[0] = 64;
    run("R6 N max", 128, 32768, 128, 1, 0, 1);
    run("R6 N over", 128, 32896, 128, 1, 0, 1);
    run("R7 K zero", 128, 256, 256, 1, 0, 1);
    run("R7 NK cap", 2, 1024, 514, 1, 0, 1);
    run("R11 enc col", 256, 32768, 256, 1, 1, 1);
    run("R11 dec col", 256, 32768, 256, 1, 0, 1);

    // R8 R9 R10 R12: layer sweeps, both modes, varied degrees
    for (int e = 0; e < 2; e++) begin
      for (int lay = 1; lay <= 12; lay++) begin
        for (int i = 0; i < 14; i++) dc_arr[i] = (i * 37 + lay * 11) % 140;
        run("R9 layer sweep", 300, 3000, 600, lay, e, lay);
        run("R12 short", 300, 3000, 600, lay, e, lay - 1 + (lay == 1 ? 2 : 0));
      end
    end

    // R10: sum boundaries in each mode
    for (int i = 0; i < 16; i++) dc_arr[i] = 128;
    dc_arr[15] = 124;
    run("R10 enc 2044", 128, 1024, 256, 16, 1, 16);
    dc_arr[15] = 125;
    run("R10 enc 2045", 128, 1024, 256, 16, 1, 16);
    for (int i = 0; i < 8; i++) dc_arr[i] = 64;
    run("R10 dec 1024 mv2", 256, 2048, 512, 8, 0, 8);
    dc_arr[7] = 65;
    run("R10 dec 1026 mv2", 256, 2048, 512, 8, 0, 8);

    // R8: layer limits
    for (int i = 0; i < 256; i++) dc_arr[i] = 2;
    run("R8 256 layers", 128, 1024, 256, 256, 1, 256);
    run("R8 128 layers mv2", 256, 2048, 512, 128, 1, 128);
    run("R8 129 layers mv2", 256, 2048, 512, 129, 1, 129);
    run("R8 zero layers", 128, 1024, 256, 0, 1, 1);

    // R13: saturation, 512 words of 128 would wrap to zero
    for (int i = 0; i < 512; i++) dc_arr[i] = 128;
    run("R13 sat", 128, 1024, 256, 256, 0, 512);

    // R3 R2: result holds while stray words arrive after done
    dc_arr[0] = 0;
    dc_arr[1] = 10;
    run("R3 base", 128, 1024, 256, 2, 0, 2);
    @(negedge clk);
    dc_valid = 1'b1; dc = 8'd0; dc_last = 1'b1;
    repeat (4) @(negedge clk);
    dc_valid = 1'b0; dc_last = 1'b0;
    @(negedge clk);
    judge("R2 after done");

    // R2: start collides with a last-flagged illegal word
    cur_p = 128; cur_n = 1024; cur_nk = 256; cur_lay = 2; cur_enc = 0;
    @(negedge clk);
    p_size = 10'd128; n_len = 16'd1024; nk_len = 16'd256; layers = 9'd2; enc = 1'b0;
    start = 1'b1; dc_valid = 1'b1; dc = 8'd0; dc_last = 1'b1;
    @(negedge clk);
    start = 1'b0; dc_valid = 1'b0; dc_last = 1'b0;
    chk("R2 collide done low", int'(done), 0);
    dc_arr[0] = 20; dc_arr[1] = 30;
    stream(2);
    judge("R2 collide");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule